// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the interrupt status of a timer/counter that has two match/capture channels. Each channel has a match/capture flag. There is also a capture-overrun error flag and a counter-overflow flag. The counter core drives per-channel event pulses into the block: compare match, capture-valid, and a read strobe for the capture register. It also drives an overflow pulse and tells the block which channels run in capture mode.

Software reads all flags as one 8-bit word. It clears a flag by writing 1 to that flag's bit. An enable vector uses the same bit layout as the flags. Each flag is gated by its enable bit, the results are ORed, and the OR is registered to form a single interrupt request.

The capture channels free their flag without a write: reading the capture register clears the flag. A new capture that arrives while the old value is still unread is reported through the error flag. That flag stays set until software clears it.

Top module: `tc_irq_flags`

## Requirements
- R1: After reset the flag word reads 0x00 and `irq_o` is 0. Asserting `rst_ni` low clears them at once.
- R2: Flag layout: bit 5 is channel 1, bit 4 is channel 0, bit 1 is the error flag and bit 0 is the overflow flag. Bits 7, 6, 3 and 2 always read 0, even after a write of 0xFF.
- R3: A compare match pulse on a channel sets that channel's flag. The flag reads 1 from the clock edge that samples the pulse.
- R4: A capture-valid pulse on a channel sets that channel's flag with the same one-edge timing.
- R5: An overflow pulse sets bit 0 with the same one-edge timing.
- R6: A write with a 1 in a flag's bit position clears that flag. A 0 in that position leaves the flag unchanged.
- R7: When a channel is in capture mode (`capt_mode_i` bit = 1), a pulse on its capture-register read strobe clears its flag. In compare mode (bit = 0) the strobe has no effect.
- R8: A capture-valid pulse on a channel whose flag is already set sets the error flag. A capture-register read or a channel flag clear does not clear the error flag; only a write of 1 to bit 1 does.
- R9: If a set event and a clear (a write of 1 or a capture-mode read) reach the same flag in the same cycle, the flag ends at 1.
- R10: `irq_en_i` uses the flag bit positions. `irq_o` goes to 1 one edge after any flag and its enable bit are both 1.
- R11: `irq_o` returns to 0 one edge after no enabled flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | NUM_CH | Per-channel compare match pulse |
| capt_valid_i | input | NUM_CH | Per-channel capture-valid pulse |
| capt_mode_i | input | NUM_CH | 1 = channel in capture mode, 0 = compare mode |
| cc_rd_i | input | NUM_CH | Per-channel capture/compare register read strobe |
| ovf_i | input | 1 | Counter overflow pulse |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | REG_W | Write data; a 1 in a bit clears that flag |
| rd_data_o | output | REG_W | Current flag word |
| irq_en_i | input | REG_W | Per-flag interrupt enable, same bit layout as the flags |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default parameters: two channels, with the channel flags starting at bit 4. This puts every implemented bit and every reserved bit of the 8-bit word in reach.

With two channels the bench can check that a clear on one channel leaves the other alone. It can also drive captures on both channels in the same cycle to see that they merge into one error flag. The table steps through same-cycle set/clear collisions and shows that a read strobe behaves differently in compare mode and capture mode. It also follows the one-edge delay between the flag word and `irq_o` while the enables change.

// File: rtl/tc_irq_pkg.sv
package tc_irq_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned OVF_BIT     = 0;
  localparam int unsigned ERR_BIT     = 1;
  localparam int unsigned CH_BIT_BASE = 4;

  function automatic logic [REG_W-1:0] impl_mask(input int unsigned n_ch);
    logic [REG_W-1:0] m;
    m = '0;
    m[OVF_BIT] = 1'b1;
    m[ERR_BIT] = 1'b1;
    for (int unsigned i = 0; i < n_ch; i++) m[CH_BIT_BASE+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tc_flag_bit.sv
module tc_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/tc_chan_ctrl.sv
module tc_chan_ctrl (
  input  logic match_i,
  input  logic capt_valid_i,
  input  logic capt_mode_i,
  input  logic cc_rd_i,
  input  logic wr_clr_i,
  input  logic flag_q_i,
  output logic set_o,
  output logic clr_o,
  output logic ovr_o
);
  logic rd_clr;

  assign rd_clr = cc_rd_i & capt_mode_i;
  assign set_o  = match_i | capt_valid_i;
  assign clr_o  = wr_clr_i | rd_clr;
  // capture lands while the previous value is still unread
  assign ovr_o  = capt_valid_i & flag_q_i;
endmodule

// File: rtl/tc_irq_combine.sv
module tc_irq_combine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic req_d, irq_q;

  assign req_d = |(flags_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= req_d;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_i & en_i)) |=> irq_o);
  assert_irq_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/tc_irq_flags.sv
module tc_irq_flags
  import tc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] match_i,
  input  logic [NUM_CH-1:0] capt_valid_i,
  input  logic [NUM_CH-1:0] capt_mode_i,
  input  logic [NUM_CH-1:0] cc_rd_i,
  input  logic              ovf_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [REG_W-1:0]  irq_en_i,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_CH);

  logic [NUM_CH-1:0] ch_q, ch_set, ch_clr, ch_ovr;
  logic              err_q, ovf_q;
  logic [REG_W-1:0]  flags;
  logic [REG_W-1:0]  wr_clr;
  logic              unused_wr;

  assign wr_clr    = wr_en_i ? wr_data_i : '0;
  assign unused_wr = ^(wr_data_i & ~IMPL);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tc_chan_ctrl u_ctrl (
      .match_i      (match_i[g]),
      .capt_valid_i (capt_valid_i[g]),
      .capt_mode_i  (capt_mode_i[g]),
      .cc_rd_i      (cc_rd_i[g]),
      .wr_clr_i     (wr_clr[CH_BIT_BASE+g]),
      .flag_q_i     (ch_q[g]),
      .set_o        (ch_set[g]),
      .clr_o        (ch_clr[g]),
      .ovr_o        (ch_ovr[g])
    );
    tc_flag_bit u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ch_set[g]),
      .clr_i  (ch_clr[g]),
      .q_o    (ch_q[g])
    );

    assert_match_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[g] |=> rd_data_o[CH_BIT_BASE+g]);
    assert_capt_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      capt_valid_i[g] |=> rd_data_o[CH_BIT_BASE+g]);
    assert_cmp_read_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o[CH_BIT_BASE+g] && cc_rd_i[g] && !capt_mode_i[g] &&
       !(wr_en_i && wr_data_i[CH_BIT_BASE+g])) |=> rd_data_o[CH_BIT_BASE+g]);
    assert_capt_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cc_rd_i[g] && capt_mode_i[g] && !match_i[g] && !capt_valid_i[g])
      |=> !rd_data_o[CH_BIT_BASE+g]);
  end

  tc_flag_bit u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (|ch_ovr),
    .clr_i  (wr_clr[ERR_BIT]),
    .q_o    (err_q)
  );

  tc_flag_bit u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_i),
    .clr_i  (wr_clr[OVF_BIT]),
    .q_o    (ovf_q)
  );

  always_comb begin
    flags          = '0;
    flags[OVF_BIT] = ovf_q;
    flags[ERR_BIT] = err_q;
    for (int unsigned i = 0; i < NUM_CH; i++) flags[CH_BIT_BASE+i] = ch_q[i];
  end

  assign rd_data_o = flags;

  tc_irq_combine #(.W(REG_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~IMPL) == '0);
  assert_ovf_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> rd_data_o[OVF_BIT]);
  assert_overrun_sets_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(capt_valid_i & rd_data_o[CH_BIT_BASE +: NUM_CH])) |=> rd_data_o[ERR_BIT]);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[ERR_BIT] && !(wr_en_i && wr_data_i[ERR_BIT])) |=> rd_data_o[ERR_BIT]);
endmodule

// File: tb/tc_irq_flags_bench.sv
`timescale 1ns/1ps
module tc_irq_flags_bench;
  typedef struct packed {
    logic [1:0] mt, cp, md, rd;
    logic       ov, we;
    logic [7:0] wd, en, ex;
  } vec_t;

  localparam int NV = 23;
  // fields: match, capture, mode, read, ovf, wr_en, wr_data, irq_en, expected flags
  localparam vec_t VEC [NV] = '{
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,8'h00}, // idle
    {2'b01,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,8'h10}, // R3 ch0
    {2'b10,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,8'h30}, // R3 ch1
    {2'b00,2'b00,2'b00,2'b00,1'b1,1'b0,8'h00,8'h00,8'h31}, // R5
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h00,8'h00,8'h31}, // R6 write 0
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h10,8'h00,8'h21}, // R6 clear ch0
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'hFF,8'h00,8'h00}, // R2 R6 all
    {2'b00,2'b01,2'b01,2'b00,1'b0,1'b0,8'h00,8'h00,8'h10}, // R4
    {2'b00,2'b00,2'b01,2'b01,1'b0,1'b0,8'h00,8'h00,8'h00}, // R7 capture read
    {2'b10,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,8'h20}, // R3
    {2'b00,2'b00,2'b00,2'b10,1'b0,1'b0,8'h00,8'h00,8'h20}, // R7 compare read
    {2'b00,2'b10,2'b10,2'b00,1'b0,1'b0,8'h00,8'h00,8'h22}, // R8 overrun
    {2'b00,2'b00,2'b10,2'b10,1'b0,1'b0,8'h00,8'h00,8'h02}, // R8 sticky on read
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h02,8'h00,8'h00}, // R8 write clear
    {2'b01,2'b00,2'b00,2'b00,1'b0,1'b1,8'h10,8'h00,8'h10}, // R9 set vs write
    {2'b00,2'b01,2'b01,2'b01,1'b0,1'b0,8'h00,8'h00,8'h12}, // R9 R8 set vs read
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'hFF,8'h01,8'h00}, // R10 masked
    {2'b00,2'b00,2'b00,2'b00,1'b1,1'b0,8'h00,8'h01,8'h01}, // R10
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h01,8'h01}, // R10 irq up
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,8'h01}, // R11 enable off
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h02,8'h01}, // R10 other enable
    {2'b00,2'b01,2'b01,2'b00,1'b0,1'b0,8'h00,8'h10,8'h11}, // R4 R10
    {2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h10,8'h11}  // R10 irq up
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] match_i = '0, capt_valid_i = '0, capt_mode_i = '0, cc_rd_i = '0;
  logic       ovf_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0, irq_en_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] prev_ex;
  logic       exp_irq;

  always #2.5 clk_i = ~clk_i;

  tc_irq_flags u_tc_irq_flags (
    .clk_i, .rst_ni, .match_i, .capt_valid_i, .capt_mode_i, .cc_rd_i,
    .ovf_i, .wr_en_i, .wr_data_i, .rd_data_o, .irq_en_i, .irq_o
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    match_i = v.mt; capt_valid_i = v.cp; capt_mode_i = v.md; cc_rd_i = v.rd;
    ovf_i = v.ov; wr_en_i = v.we; wr_data_i = v.wd; irq_en_i = v.en;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset flags", rd_data_o, 8'h00);
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    prev_ex = 8'h00;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      exp_irq = |(prev_ex & VEC[i].en);
      @(negedge clk_i);
      chk($sformatf("R2-map vec %0d flags", i), rd_data_o, VEC[i].ex);
      chk($sformatf("R10/R11 vec %0d irq", i), {7'd0, irq_o}, {7'd0, exp_irq});
      prev_ex = VEC[i].ex;
    end

    // both channels overrun in one cycle: R8
    drive('0);
    wr_en_i = 1'b1; wr_data_i = 8'hFF;
    @(negedge clk_i);
    drive('0);
    match_i = 2'b11;
    @(negedge clk_i);
    chk("R3 both channels", rd_data_o, 8'h30);
    drive('0);
    capt_valid_i = 2'b11; capt_mode_i = 2'b11;
    @(negedge clk_i);
    chk("R8 dual overrun", rd_data_o, 8'h32);
    drive('0);
    capt_mode_i = 2'b11; cc_rd_i = 2'b01;
    @(negedge clk_i);
    chk("R7 read ch0 only", rd_data_o, 8'h22);
    drive('0);
    wr_en_i = 1'b1; wr_data_i = 8'h20;
    @(negedge clk_i);
    chk("R8 err survives flag clear", rd_data_o, 8'h02);
    drive('0);
    ovf_i = 1'b1; irq_en_i = 8'h01;
    @(negedge clk_i);
    drive('0);
    irq_en_i = 8'h01;
    @(negedge clk_i);
    chk("R10 irq before reset", {7'd0, irq_o}, 8'h01);

    // asynchronous reset mid-cycle: R1
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async flags", rd_data_o, 8'h00);
    chk("R1 async irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", rd_data_o, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule